// File: doc/BRIEF.md
# Deferred-Load Retire Station Pool

This block keeps loads that are in flight until the cycle the schedule has chosen for their retirement. Each cycle, up to a fixed number of load ports may issue a load. Every issued load takes the lowest-numbered idle station and sends a memory request that carries that station's index. A load is deferred in one of two ways. It may carry a count of issue cycles, or it may carry a tag that a later retire request names. Memory responses can come back in any order, and each one writes its data into the station it names.

When a station's retire point arrives and its data is present, the value goes out on a retire lane and the station becomes idle again. When the retire point arrives before the data, the block raises stall. While stall is high, nothing retires, no new load is accepted and the deferral counts hold their values. A cycle with stall low is an issue cycle. With the three-cycle cache latency assumed here, any count deferral below three always produces a stall, even on a hit. Issuing a load when every station is busy raises an error flag, and that load is dropped.

Top module: `load_retire_pool`

## Requirements
- R1: In an issue cycle, each valid port in ascending port order takes the lowest idle station not already taken by a lower port. The same cycle, that port's memory request is valid and carries the station index.
- R2: A count-deferred load (mode bit 0, deferral d from 0 to 2^CW-1) retires in the (d+1)-th issue cycle after its issue cycle.
- R3: A tag-deferred load (mode bit 1) never retires on its own. It retires in the first issue cycle in which a retire request presents its tag. A request with a different tag does nothing.
- R4: A memory response stores its data in the named station, and that data is what the station later delivers.
- R5: If a station is at its retire point and its data has not arrived, stall is high. During stall nothing retires, issue inputs are ignored (no memory request) and counts hold. A response that arrives during stall ends the stall in the next cycle, and the load retires in that cycle.
- R6: Stations that retire in the same cycle come out on lanes 0, 1, 2, … in ascending station-index order, and the used lanes are contiguous from lane 0.
- R7: A valid port that finds no idle station raises iss_err in that cycle, and its memory request stays low.
- R8: A retiring station is idle from the next cycle on. It cannot be taken in its own retire cycle.
- R9: After reset all stations are idle, and stall, iss_err and every ret_vld are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_vld | input | NPORT | Load valid per port |
| iss_tagmode | input | NPORT | 1 = tag deferral, 0 = count deferral |
| iss_cnt | input | NPORT x CW | Count deferral per port |
| iss_tag | input | NPORT x TW | Retire tag per port |
| iss_addr | input | NPORT x AW | Load address per port |
| mem_req_vld | output | NPORT | Memory request valid per port |
| mem_req_addr | output | NPORT x AW | Request address |
| mem_req_stn | output | NPORT x SW | Station index the response must name |
| mem_rsp_vld | input | 1 | Memory response valid |
| mem_rsp_stn | input | SW | Station the response targets |
| mem_rsp_data | input | DW | Response data |
| rtr_vld | input | 1 | Tag retire request valid |
| rtr_tag | input | TW | Tag to retire |
| ret_vld | output | NSTN | Retire lane valid |
| ret_stn | output | NSTN x SW | Station delivered on each lane |
| ret_data | output | NSTN x DW | Data delivered on each lane |
| stall | output | 1 | Core stall: a due load lacks data |
| iss_err | output | 1 | A load found no idle station |

## Verification
Retirement and issue can happen in the same cycle. To provoke this, the bench issues a new load in the exact cycle a group of stations retires. It then checks that the new load is placed in a station that was already idle, and that a retired station is only handed out again in the following cycle. A memory response can also arrive while the block is stalled. The bench holds a zero-deferral load in stall for several cycles, tries to issue during the stall, delivers the data partway through, and checks that issue stayed blocked, that stall stayed high in the arrival cycle, and that the value retired in the next cycle.

// File: rtl/load_retire_pool.sv
module load_retire_pool #(
  parameter int NSTN  = 8,
  parameter int NPORT = 4,
  parameter int CW    = 3,
  parameter int TW    = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int SW   = $clog2(NSTN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           iss_vld,
  input  logic [NPORT-1:0]           iss_tagmode,
  input  logic [NPORT-1:0][CW-1:0]   iss_cnt,
  input  logic [NPORT-1:0][TW-1:0]   iss_tag,
  input  logic [NPORT-1:0][AW-1:0]   iss_addr,
  output logic [NPORT-1:0]           mem_req_vld,
  output logic [NPORT-1:0][AW-1:0]   mem_req_addr,
  output logic [NPORT-1:0][SW-1:0]   mem_req_stn,
  input  logic                       mem_rsp_vld,
  input  logic [SW-1:0]              mem_rsp_stn,
  input  logic [DW-1:0]              mem_rsp_data,
  input  logic                       rtr_vld,
  input  logic [TW-1:0]              rtr_tag,
  output logic [NSTN-1:0]            ret_vld,
  output logic [NSTN-1:0][SW-1:0]    ret_stn,
  output logic [NSTN-1:0][DW-1:0]    ret_data,
  output logic                       stall,
  output logic                       iss_err
);

  logic [NSTN-1:0]          busy, tagm, dv, due, fire;
  logic [NSTN-1:0][CW-1:0]  cnt;
  logic [NSTN-1:0][TW-1:0]  tagq;
  logic [NSTN-1:0][DW-1:0]  dat;

  always_comb begin
    for (int s = 0; s < NSTN; s++)
      due[s] = busy[s] & (tagm[s] ? (rtr_vld && tagq[s] == rtr_tag) : (cnt[s] == '0));
  end

  assign stall = |(due & ~dv);
  assign fire  = stall ? '0 : due;
  assign mem_req_addr = iss_addr;

  // lowest idle station per port, ports served in ascending order
  always_comb begin
    logic [NSTN-1:0] taken;
    logic found;
    taken   = busy;
    iss_err = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      mem_req_vld[p] = 1'b0;
      mem_req_stn[p] = '0;
      found = 1'b0;
      if (iss_vld[p] && !stall) begin
        for (int s = 0; s < NSTN; s++)
          if (!taken[s] && !found) begin
            found = 1'b1;
            mem_req_stn[p] = SW'(s);
          end
        if (found) begin
          mem_req_vld[p] = 1'b1;
          taken[mem_req_stn[p]] = 1'b1;
        end else begin
          iss_err = 1'b1;
        end
      end
    end
  end

  // pack retiring stations onto lanes in station order
  always_comb begin
    int k;
    k = 0;
    ret_vld  = '0;
    ret_stn  = '0;
    ret_data = '0;
    for (int s = 0; s < NSTN; s++)
      if (fire[s]) begin
        ret_vld[k]  = 1'b1;
        ret_stn[k]  = SW'(s);
        ret_data[k] = dat[s];
        k = k + 1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      tagm <= '0;
      dv   <= '0;
      cnt  <= '0;
      tagq <= '0;
      dat  <= '0;
    end else begin
      for (int s = 0; s < NSTN; s++) begin
        if (mem_rsp_vld && mem_rsp_stn == SW'(s)) begin
          dv[s]  <= 1'b1;
          dat[s] <= mem_rsp_data;
        end
        if (!stall && busy[s] && !tagm[s] && cnt[s] != '0)
          cnt[s] <= cnt[s] - 1'b1;
        if (fire[s]) begin
          busy[s] <= 1'b0;
          dv[s]   <= 1'b0;
        end
      end
      for (int p = 0; p < NPORT; p++)
        if (mem_req_vld[p]) begin
          busy[mem_req_stn[p]] <= 1'b1;
          dv[mem_req_stn[p]]   <= 1'b0;
          tagm[mem_req_stn[p]] <= iss_tagmode[p];
          cnt[mem_req_stn[p]]  <= iss_cnt[p];
          tagq[mem_req_stn[p]] <= iss_tag[p];
        end
    end
  end

  logic [NSTN-1:0] lane_next;
  assign lane_next = ret_vld + NSTN'(1);

  assert_lanes_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_next & ret_vld) == '0);
  assert_no_retire_in_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ret_vld == '0 && mem_req_vld == '0));
  assert_count_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mem_req_vld == '0) |=> $stable(cnt));
  assert_err_only_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_err |-> ($countones(~busy) < NPORT));
  assert_rsp_to_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_vld |-> busy[mem_rsp_stn]);
  assert_freed_after_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[0] && !mem_req_vld[0]) |=> !busy[0]);

endmodule

// File: tb/tb_load_retire_pool.sv
module tb_load_retire_pool;
  localparam int NSTN = 8, NPORT = 4, CW = 3, TW = 8, AW = 32, DW = 32, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NPORT-1:0] iss_vld, iss_tagmode;
  logic [NPORT-1:0][CW-1:0] iss_cnt;
  logic [NPORT-1:0][TW-1:0] iss_tag;
  logic [NPORT-1:0][AW-1:0] iss_addr;
  logic [NPORT-1:0] mem_req_vld;
  logic [NPORT-1:0][AW-1:0] mem_req_addr;
  logic [NPORT-1:0][SW-1:0] mem_req_stn;
  logic mem_rsp_vld;
  logic [SW-1:0] mem_rsp_stn;
  logic [DW-1:0] mem_rsp_data;
  logic rtr_vld;
  logic [TW-1:0] rtr_tag;
  logic [NSTN-1:0] ret_vld;
  logic [NSTN-1:0][SW-1:0] ret_stn;
  logic [NSTN-1:0][DW-1:0] ret_data;
  logic stall, iss_err;

  int total = 0, bad = 0, cyc_n = 0;
  bit done = 0;

  always #10 clk = ~clk;

  load_retire_pool dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_vld = '0; iss_tagmode = '0; iss_cnt = '0; iss_tag = '0; iss_addr = '0;
    mem_rsp_vld = 0; mem_rsp_stn = '0; mem_rsp_data = '0; rtr_vld = 0; rtr_tag = '0;
  endtask

  task automatic nxt();
    @(negedge clk);
    idle();
  endtask

  task automatic rsp(input int s, input logic [DW-1:0] d);
    mem_rsp_vld = 1; mem_rsp_stn = SW'(s); mem_rsp_data = d;
  endtask

  task automatic t_reset();
    #1;
    chk(stall == 0 && iss_err == 0 && ret_vld == '0, "R9 reset", {stall, iss_err, ret_vld}, 0);
  endtask

  task automatic t_count();
    iss_vld[0] = 1; iss_cnt[0] = 3; iss_addr[0] = 32'h100;
    #1;
    chk(mem_req_vld == 4'b0001 && mem_req_stn[0] == 0 && mem_req_addr[0] == 32'h100,
        "R1 first grant", mem_req_stn[0], 0);
    nxt();
    rsp(0, 32'hC0DE_0001);
    for (int c = 1; c <= 3; c++) begin
      #1;
      chk(ret_vld == '0 && stall == 0, "R2 not early", ret_vld, 0);
      nxt();
    end
    #1;
    chk(ret_vld == 8'h01 && ret_stn[0] == 0, "R2 retire at d+1", ret_vld, 1);
    chk(ret_data[0] == 32'hC0DE_0001, "R4 data", ret_data[0], 32'hC0DE_0001);
    nxt();
  endtask

  task automatic t_stall();
    iss_vld[0] = 1; iss_cnt[0] = 0;
    nxt();
    iss_vld[0] = 1; iss_cnt[0] = 0;
    #1;
    chk(stall == 1, "R5 stall on late data", stall, 1);
    chk(mem_req_vld == '0 && ret_vld == '0, "R5 issue ignored in stall", mem_req_vld, 0);
    nxt();
    rsp(0, 32'h5A5A_0002);
    #1;
    chk(stall == 1, "R5 stall in arrival cycle", stall, 1);
    nxt();
    #1;
    chk(stall == 0 && ret_vld == 8'h01 && ret_data[0] == 32'h5A5A_0002,
        "R5 retire after arrival", ret_data[0], 32'h5A5A_0002);
    nxt();
    #1;
    chk(ret_vld == '0, "R5 no double retire", ret_vld, 0);
  endtask

  task automatic t_tag();
    iss_vld[1] = 1; iss_tagmode[1] = 1; iss_tag[1] = 8'h5A;
    #1;
    chk(mem_req_vld == 4'b0010 && mem_req_stn[1] == 0, "R1 port1 lowest", mem_req_stn[1], 0);
    nxt();
    rsp(0, 32'hBEEF_0003);
    nxt();
    for (int c = 0; c < 10; c++) begin
      #1;
      chk(ret_vld == '0, "R3 tag waits", ret_vld, 0);
      nxt();
    end
    rtr_vld = 1; rtr_tag = 8'h33;
    #1;
    chk(ret_vld == '0, "R3 wrong tag", ret_vld, 0);
    nxt();
    rtr_vld = 1; rtr_tag = 8'h5A;
    #1;
    chk(ret_vld == 8'h01 && ret_data[0] == 32'hBEEF_0003, "R3 tag retire", ret_data[0], 32'hBEEF_0003);
    nxt();
  endtask

  task automatic t_multi();
    int order[4] = '{3, 1, 0, 2};
    iss_vld = 4'hF; iss_cnt = {3'd5, 3'd5, 3'd5, 3'd5};
    #1;
    for (int p = 0; p < NPORT; p++)
      chk(mem_req_stn[p] == SW'(p), "R1 port order", mem_req_stn[p], p);
    nxt();
    for (int c = 0; c < 4; c++) begin
      rsp(order[c], 32'hD000_0000 + order[c]);
      nxt();
    end
    #1;
    chk(ret_vld == '0, "R2 group not early", ret_vld, 0);
    nxt();
    iss_vld[0] = 1; iss_tagmode[0] = 1; iss_tag[0] = 8'h11;
    #1;
    chk(ret_vld == 8'h0F, "R6 four lanes", ret_vld, 8'h0F);
    for (int k = 0; k < 4; k++)
      chk(ret_stn[k] == SW'(k) && ret_data[k] == 32'hD000_0000 + k, "R6 lane order", ret_stn[k], k);
    chk(mem_req_stn[0] == 4, "R8 no reuse in retire cycle", mem_req_stn[0], 4);
    nxt();
    iss_vld[0] = 1; iss_tagmode[0] = 1; iss_tag[0] = 8'h11;
    #1;
    chk(mem_req_vld[0] && mem_req_stn[0] == 0, "R8 reuse next cycle", mem_req_stn[0], 0);
    nxt();
    rsp(4, 32'h4444);
    nxt();
    rsp(0, 32'h0);
    nxt();
    rtr_vld = 1; rtr_tag = 8'h11;
    #1;
    chk(ret_vld == 8'h03 && ret_stn[0] == 0 && ret_stn[1] == 4 && ret_data[1] == 32'h4444,
        "R6 index order", {ret_stn[1], ret_stn[0]}, 8'h20);
    nxt();
  endtask

  task automatic t_full();
    iss_vld = 4'hF; iss_tagmode = 4'hF; iss_tag = {4{8'h22}};
    nxt();
    iss_vld = 4'hF; iss_tagmode = 4'hF; iss_tag = {4{8'h22}};
    #1;
    chk(iss_err == 0 && mem_req_stn[3] == 7, "R7 fill no error", mem_req_stn[3], 7);
    nxt();
    iss_vld[0] = 1;
    #1;
    chk(iss_err == 1 && mem_req_vld == '0, "R7 full error", {iss_err, mem_req_vld}, 5'h10);
    nxt();
    for (int s = 0; s < NSTN; s++) begin
      rsp(s, 32'hE000_0000 + s);
      nxt();
    end
    rtr_vld = 1; rtr_tag = 8'h22;
    #1;
    chk(ret_vld == 8'hFF, "R6 all lanes", ret_vld, 8'hFF);
    for (int k = 0; k < NSTN; k++)
      chk(ret_stn[k] == SW'(k) && ret_data[k] == 32'hE000_0000 + k, "R6 full lanes", ret_data[k], 32'hE000_0000 + k);
    nxt();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    nxt();
    t_count();
    t_stall();
    t_tag();
    t_multi();
    t_full();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 5000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc_n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule